// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block runs the handshake that moves the system clock between full, one-half and one-thirty-second speed. Software writes a selection into a control input. A 0-to-1 edge on exactly one valid selection bit starts a sequence:

1. The block pulls its active-low freeze line and waits, for as long as it takes, for the devices to acknowledge.
2. It asserts an active-low clock-change code that names the target ratio.
3. It raises a PLL bypass signal, then releases it.
4. It releases the clock-change code.
5. It lets the PLL settle before it lifts the freeze.

Five programmable delays set the length of each interval. Every delay counts block clock cycles, and the block clock runs at half the system frequency. A delay of zero makes its interval one cycle long.

A busy flag covers the whole sequence. A one-cycle done pulse marks its end, and at that same edge the new ratio appears on an output for neighbouring logic. Programming the target frequency into the devices is outside this block, and so is the PLL.

Top module: `clk_ratio_seq`

## Requirements
- R1: With the block idle, a 0-to-1 edge on one valid selection bit starts a sequence, provided exactly one valid bit is then set. The valid bits are sel[0] for full speed, sel[1] for half speed and sel[5] for 1/32 speed. From the next cycle, busy is 1 and freeze_n is 0.
- R2: No sequence starts in three cases. The first is an edge while more than one valid bit is set. The second is a level held from before. The third is a change on the reserved bits sel[4:2].
- R3: The block holds freeze_n low for as long as freeze_ack stays low. Once freeze_ack is seen, it waits dly_ack+1 cycles before it asserts the change code.
- R4: chg_n carries the inverted one-hot code while asserted: bit 0 for full, bit 1 for half, bit 2 for 1/32. It is held alone for dly_byp_on+1 cycles, and then pll_bypass rises.
- R5: pll_bypass stays high for dly_byp_off+1 cycles.
- R6: After pll_bypass falls, chg_n stays asserted for dly_chg_off+1 more cycles.
- R7: After chg_n returns to 3'b111, freeze_n stays low for dly_settle+1 cycles and then goes high.
- R8: busy stays high from the start until the block is idle again. A selection edge seen while busy is dropped. Clearing sel during a sequence does not stop it.
- R9: done pulses for exactly one cycle as busy falls. At that same edge ratio takes the new value: 0 for full, 1 for half, 2 for 1/32.
- R10: During and after reset: freeze_n=1, chg_n=3'b111, pll_bypass=0, busy=0, done=0, ratio=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (half system rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 6 | Control selection: bits 0, 1 and 5 are valid, the rest are reserved |
| dly_ack | input | 8 | Cycles from acknowledge to change assertion, minus one |
| dly_byp_on | input | 16 | Cycles from change assertion to bypass assertion, minus one |
| dly_byp_off | input | 8 | Bypass hold length, minus one |
| dly_chg_off | input | 8 | Change hold after bypass release, minus one |
| dly_settle | input | 32 | Cycles from change release to freeze release, minus one |
| freeze_ack | input | 1 | Devices report that they are frozen |
| freeze_n | output | 1 | Active-low freeze request |
| chg_n | output | 3 | Active-low clock-change code |
| pll_bypass | output | 1 | PLL bypass request |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| ratio | output | 2 | Current ratio: 0 full, 1 half, 2 one-thirty-second |

## Verification
The bench runs one sequence for each valid selection bit. Each run uses its own mix of delays, including all-zero delays and long settle times. This shows that every interval is timed by its own register, and that the code and the ratio follow the chosen bit. The acknowledge is held back for several cycles before it is given, which tells a waiting freeze phase apart from a timed one. Selections with two valid bits, changes on the reserved bits only, a level left high and a new edge during a sequence must all leave the block idle or unchanged. That separates true edge detection from simple level decoding.

// File: rtl/clk_ratio_seq.sv
module clk_ratio_seq #(
  parameter int SEL_W    = 6,
  parameter int ACK_W    = 8,
  parameter int BYP_ON_W = 16,
  parameter int OFF_W    = 8,
  parameter int SET_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SEL_W-1:0]    sel,
  input  logic [ACK_W-1:0]    dly_ack,
  input  logic [BYP_ON_W-1:0] dly_byp_on,
  input  logic [OFF_W-1:0]    dly_byp_off,
  input  logic [OFF_W-1:0]    dly_chg_off,
  input  logic [SET_W-1:0]    dly_settle,
  input  logic                freeze_ack,
  output logic                freeze_n,
  output logic [2:0]          chg_n,
  output logic                pll_bypass,
  output logic                busy,
  output logic                done,
  output logic [1:0]          ratio
);

  typedef enum logic [2:0] {
    S_IDLE, S_FREEZE, S_ACT, S_CHG, S_BYP, S_DEASRT, S_SETTLE
  } state_t;

  state_t           state;
  logic [SEL_W-1:0] sel_q;
  logic [2:0]       code;
  logic [SET_W-1:0] cnt, lim;
  logic [2:0]       valid, rise;
  logic             start, hit;

  assign valid = {sel[5], sel[1], sel[0]};
  assign rise  = valid & ~{sel_q[5], sel_q[1], sel_q[0]};
  assign start = (rise != 3'b000) && $onehot(valid);

  always_comb begin
    case (state)
      S_ACT:    lim = SET_W'(dly_ack);
      S_CHG:    lim = SET_W'(dly_byp_on);
      S_BYP:    lim = SET_W'(dly_byp_off);
      S_DEASRT: lim = SET_W'(dly_chg_off);
      S_SETTLE: lim = dly_settle;
      default:  lim = '0;
    endcase
  end
  assign hit = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sel_q <= '0;
      code  <= 3'b001;
      cnt   <= '0;
      done  <= 1'b0;
      ratio <= 2'd0;
    end else begin
      sel_q <= sel;
      done  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          code  <= valid;
          state <= S_FREEZE;
        end
        S_FREEZE: if (freeze_ack) begin
          cnt   <= '0;
          state <= S_ACT;
        end
        default: begin
          if (!hit) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            case (state)
              S_ACT:    state <= S_CHG;
              S_CHG:    state <= S_BYP;
              S_BYP:    state <= S_DEASRT;
              S_DEASRT: state <= S_SETTLE;
              default: begin
                state <= S_IDLE;
                done  <= 1'b1;
                ratio <= code[2] ? 2'd2 : (code[1] ? 2'd1 : 2'd0);
              end
            endcase
          end
        end
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign freeze_n   = !busy;
  assign pll_bypass = (state == S_BYP);
  assign chg_n      = (state inside {S_CHG, S_BYP, S_DEASRT}) ? ~code : 3'b111;

endmodule

module clk_ratio_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] sel,
  input logic       freeze_n,
  input logic [2:0] chg_n,
  input logic       pll_bypass,
  input logic       busy,
  input logic       done,
  input logic [1:0] ratio
);
  AST_NO_START_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $countones({sel[5], sel[1:0]}) > 1) |=> !busy); // R2
  AST_CHG_UNDER_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_n != 3'b111) |-> !freeze_n); // R4
  AST_CHG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~chg_n)); // R4
  AST_BYP_UNDER_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    pll_bypass |-> (chg_n != 3'b111)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (freeze_n && chg_n == 3'b111 && !pll_bypass)); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $past(busy))); // R9
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(ratio)); // R9
endmodule

bind clk_ratio_seq clk_ratio_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .freeze_n(freeze_n), .chg_n(chg_n),
  .pll_bypass(pll_bypass), .busy(busy), .done(done), .ratio(ratio)
);

// File: tb/tb_clk_ratio_seq.sv
module tb_clk_ratio_seq;
  logic clk = 0, rst_n = 0;
  logic [5:0] sel = '0;
  logic [7:0] dly_ack = '0, dly_byp_off = '0, dly_chg_off = '0;
  logic [15:0] dly_byp_on = '0;
  logic [31:0] dly_settle = '0;
  logic freeze_ack = 0;
  logic freeze_n, pll_bypass, busy, done;
  logic [2:0] chg_n;
  logic [1:0] ratio;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clk_ratio_seq dut (.*);

  localparam int NV = 5;
  localparam logic [5:0]  V_SEL [NV] = '{6'h02, 6'h20, 6'h01, 6'h22, 6'h02};
  localparam logic [7:0]  V_ACK [NV] = '{8'd0, 8'd3, 8'd7, 8'd1, 8'd2};
  localparam logic [15:0] V_BON [NV] = '{16'd0, 16'd5, 16'd2, 16'd9, 16'd1};
  localparam logic [7:0]  V_BOF [NV] = '{8'd0, 8'd2, 8'd6, 8'd1, 8'd4};
  localparam logic [7:0]  V_COF [NV] = '{8'd0, 8'd4, 8'd1, 8'd3, 8'd0};
  localparam logic [31:0] V_SET [NV] = '{32'd0, 32'd40, 32'd3, 32'd11, 32'd2};
  localparam logic [2:0]  V_CODE[NV] = '{3'b010, 3'b100, 3'b001, 3'b100, 3'b010};
  localparam logic [1:0]  V_RAT [NV] = '{2'd1, 2'd2, 2'd0, 2'd2, 2'd1};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // runs one sequence; sel is cleared after clr_at samples (0 = left set)
  task automatic run(input int i, input int clr_at);
    int nfz = 0, nact = 0, nchg = 0, nbyp = 0, ndact = 0, nset = 0, n = 0;
    bit ack_on = 0, seen_chg = 0, seen_byp = 0;
    logic [2:0] code = '0;
    dly_ack = V_ACK[i]; dly_byp_on = V_BON[i]; dly_byp_off = V_BOF[i];
    dly_chg_off = V_COF[i]; dly_settle = V_SET[i];
    @(negedge clk); sel = V_SEL[i];
    @(negedge clk);
    chk("R1 busy after edge", busy, 1);
    chk("R1 freeze low", freeze_n, 0);
    while (busy && n < 2000) begin
      if (!freeze_n && chg_n == 3'b111 && !seen_chg) begin
        if (ack_on) nact++;
        else begin nfz++; if (nfz == 3) begin freeze_ack = 1; ack_on = 1; end end
      end else if (chg_n != 3'b111 && !pll_bypass && !seen_byp) begin
        nchg++; seen_chg = 1; code = ~chg_n;
      end else if (pll_bypass) begin nbyp++; seen_byp = 1; end
      else if (chg_n != 3'b111) ndact++;
      else if (!freeze_n) nset++;
      n++;
      if (n == clr_at) sel = '0;
      @(negedge clk);
    end
    freeze_ack = 0;
    chk("R3 waited for ack", nfz, 3);
    chk("R3 ack delay", nact, V_ACK[i] + 1);
    chk("R4 change code", code, V_CODE[i]);
    chk("R4 change before bypass", nchg, V_BON[i] + 1);
    chk("R5 bypass length", nbyp, V_BOF[i] + 1);
    chk("R6 change hold", ndact, V_COF[i] + 1);
    chk("R7 settle length", nset, V_SET[i] + 1);
    chk("R9 done pulse", done, 1);
    chk("R9 ratio", ratio, V_RAT[i]);
    chk("R8 idle quiet", {freeze_n, chg_n, pll_bypass}, 5'b11110);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic expect_idle(input string req, input int cyc);
    int hi = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (busy) hi++; end
    chk(req, hi, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    @(negedge clk);
    chk("R10 reset freeze_n", freeze_n, 1);
    chk("R10 reset chg_n", chg_n, 3'b111);
    chk("R10 reset outputs", {pll_bypass, busy, done, ratio}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      if (V_SEL[i] == 6'h22) begin
        // two valid bits at once: no start
        sel = V_SEL[i];
        expect_idle("R2 two bits ignored", 6);
        chk("R2 ratio kept", ratio, V_RAT[i-1]);
        sel = '0; @(negedge clk);
        continue;
      end
      run(i, (i == 2) ? 0 : 8);
      if (i == 2) begin
        expect_idle("R2 held level no restart", 8);
        sel = '0; @(negedge clk);
      end
    end
    // reserved bits only
    sel = 6'h1c;
    expect_idle("R2 reserved bits ignored", 6);
    sel = '0; @(negedge clk);
    // new edge during a sequence is dropped, clear does not abort
    dly_ack = 0; dly_byp_on = 0; dly_byp_off = 0; dly_chg_off = 0; dly_settle = 20;
    sel = 6'h01; @(negedge clk);
    freeze_ack = 1;
    sel = '0; @(negedge clk);
    sel = 6'h20;
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk("R8 busy through clear and new edge", busy, 1);
    for (int k = 0; k < 60 && busy; k++) @(negedge clk);
    freeze_ack = 0;
    chk("R8 first selection wins", ratio, 0);
    sel = '0;
    expect_idle("R8 dropped edge not replayed", 5);
    // reset during a sequence
    sel = 6'h02; @(negedge clk); sel = '0; @(negedge clk);
    rst_n = 0; @(negedge clk);
    chk("R10 reset aborts", {busy, freeze_n, chg_n}, 5'b01111);
    rst_n = 1; @(negedge clk);
    finish_run();
  end
endmodule